// File: doc/BRIEF.md
# Cascadable Synchronous Counter Slice

The block is a narrow synchronous binary up-counter meant to be used as one stage of a wider counter. Each rising clock edge applies exactly one of four actions to the register: clear to zero, load from the parallel data inputs, increment, or hold. The actions are ranked, and when several are requested at once the highest-ranked one wins.

Two count enables are provided so that several slices can be joined without extra gates. The trickle enable gates both counting and the terminal-count output. The parallel enable gates counting only. The terminal-count output is combinational. In a lookahead chain, the first stage's terminal count feeds the parallel enable of every later stage, and each stage's terminal count feeds the trickle enable of the next stage.

A synchronous active-high reset is provided in addition to the functional clear.

Top module: `sync_count_slice`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes all zeros on that edge. `rst` overrides every other input.
- R2: When `rst` is low and `clr_n` is low at a rising edge, `q` becomes all zeros, whatever `load_n`, `din`, `en_par` and `en_trk` are.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, whatever either count enable is.
- R4: When `clr_n` and `load_n` are both high and `en_par` and `en_trk` are both high at a rising edge, `q` increments by one.
- R5: Incrementing from the all-ones value (15 for a width of 4) gives zero.
- R6: When `clr_n` and `load_n` are both high and either count enable is low at a rising edge, `q` keeps its value.
- R7: `tc` is 1 exactly when `en_trk` is 1 and `q` is all ones. It does not depend on `en_par` and needs no clock edge.
- R8: Three slices joined in the lookahead arrangement count as one 12-bit counter. That counter wraps from 4095 to 0, and its last stage's `tc` is 1 only at 4095 with counting enabled.
- R9: Inputs are sampled only at rising edges. A pulse on any control input that starts and ends between two edges leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes occur on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| clr_n | input | 1 | Synchronous clear, active low. |
| load_n | input | 1 | Synchronous parallel load, active low. |
| din | input | WIDTH | Value copied into the register when a load occurs. |
| en_par | input | 1 | Parallel count enable, active high. |
| en_trk | input | 1 | Trickle count enable, active high. Also gates `tc`. |
| q | output | WIDTH | Counter register. |
| tc | output | 1 | Terminal count: all ones while `en_trk` is high. |

## Verification
The single slice is driven through combined control patterns that request several actions at once, such as a clear with a load and both enables asserted, or a load with both enables high. These patterns show whether the ranking of the actions is correct. Each enable is dropped on its own at the all-ones value. This separates a hold caused by the parallel enable from one caused by the trickle enable, and shows that only the trickle enable gates `tc`. A 12-bit lookahead chain is loaded close to its top value and run through the wrap, with a load and a clear placed in the middle of counting. Short control pulses between clock edges show that no input is sampled outside the edge.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    SCS_HOLD  = 2'd0,
    SCS_COUNT = 2'd1,
    SCS_LOAD  = 2'd2,
    SCS_CLEAR = 2'd3
  } scs_mode_e;
endpackage

// File: rtl/scs_mode_sel.sv
module scs_mode_sel
  import scs_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output scs_mode_e mode
);
  // ranked choice: clear, then load, then count, then hold
  always_comb begin
    if (!clr_n)                mode = SCS_CLEAR;
    else if (!load_n)          mode = SCS_LOAD;
    else if (en_par && en_trk) mode = SCS_COUNT;
    else                       mode = SCS_HOLD;
  end
endmodule

// File: rtl/scs_next.sv
module scs_next
  import scs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  scs_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode)
      SCS_CLEAR: nxt = '0;
      SCS_LOAD:  nxt = din;
      SCS_COUNT: nxt = cur + ONE;  // natural wrap at all ones
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/scs_term.sv
module scs_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign tc = en_trk && (cur == TOP);
endmodule

// File: rtl/sync_count_slice.sv
module sync_count_slice
  import scs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  scs_mode_e        mode;
  logic [WIDTH-1:0] nxt;

  scs_mode_sel u_sel (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  scs_next #(.WIDTH(WIDTH)) u_next (
    .mode (mode),
    .cur  (q),
    .din  (din),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  scs_term #(.WIDTH(WIDTH)) u_term (
    .cur    (q),
    .en_trk (en_trk),
    .tc     (tc)
  );
endmodule

// File: rtl/sync_count_slice_chk.sv
module sync_count_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!past_ok)
    $past(rst) |-> q == '0);
  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !clr_n |=> q == '0);
  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr_n && !load_n) |=> q == $past(din));
  // R4
  count_inc_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr_n && load_n && en_par && en_trk) |=> q == $past(q) + WIDTH'(1));
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr_n && load_n && en_par && en_trk && (&q)) |=> q == '0);
  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));
  // R7
  tc_needs_trk_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    tc |-> (en_trk && (&q)));
  // R7
  tc_at_top_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (en_trk && (&q)) |-> tc);
endmodule

bind sync_count_slice sync_count_slice_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sync_count_slice_tb_top.sv
module sync_count_slice_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad   = 0;

  // single slice
  logic       clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       tc;

  sync_count_slice #(.WIDTH(4)) dut_i (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q), .tc(tc)
  );

  // three-slice lookahead chain (R8)
  logic        c_clr_n = 1'b1, c_load_n = 1'b1, c_en = 1'b0;
  logic [11:0] c_din = '0;
  logic [11:0] c_q;
  logic [2:0]  c_tc;
  logic [2:0]  c_ep, c_et;

  for (genvar s = 0; s < 3; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign c_ep[s] = c_en;
      assign c_et[s] = c_en;
    end else begin : g_rest
      assign c_ep[s] = c_tc[0];
      assign c_et[s] = c_tc[s-1];
    end
    sync_count_slice #(.WIDTH(4)) u_s (
      .clk(clk), .rst(rst), .clr_n(c_clr_n), .load_n(c_load_n),
      .din(c_din[4*s +: 4]), .en_par(c_ep[s]), .en_trk(c_et[s]),
      .q(c_q[4*s +: 4]), .tc(c_tc[s])
    );
  end

  int exp_q = 0;
  int exp_c = 0;

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one clock on the single slice, reference updated behaviourally
  task automatic step(string req, bit cn, bit ln, bit ep, bit et, int d);
    clr_n = cn; load_n = ln; en_par = ep; en_trk = et; din = 4'(d);
    if (!cn)           exp_q = 0;
    else if (!ln)      exp_q = d % 16;
    else if (ep && et) exp_q = (exp_q + 1) % 16;
    @(posedge clk); @(negedge clk);
    chk(req, int'(q), exp_q);
    chk("R7", int'(tc), (et && exp_q == 15) ? 1 : 0);
  endtask

  task automatic cstep(string req, bit cn, bit ln, bit en, int d);
    c_clr_n = cn; c_load_n = ln; c_en = en; c_din = 12'(d);
    if (!cn)      exp_c = 0;
    else if (!ln) exp_c = d % 4096;
    else if (en)  exp_c = (exp_c + 1) % 4096;
    @(posedge clk); @(negedge clk);
    chk(req, int'(c_q), exp_c);
    chk("R8", int'(c_tc[2]), (en && exp_c == 4095) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(q), 0);
    chk("R1", int'(c_q), 0);
    rst = 1'b0;

    step("R4", 1, 1, 1, 1, 0);
    step("R4", 1, 1, 1, 1, 0);
    step("R6", 1, 1, 0, 1, 0);
    step("R6", 1, 1, 1, 0, 0);
    step("R3", 1, 0, 0, 0, 13);
    step("R3", 1, 0, 1, 1, 14);
    step("R4", 1, 1, 1, 1, 3);
    // at 15: each enable dropped alone
    step("R6", 1, 1, 0, 1, 0);
    chk("R7", int'(tc), 1);
    step("R6", 1, 1, 1, 0, 0);
    chk("R7", int'(tc), 0);
    step("R5", 1, 1, 1, 1, 0);
    step("R4", 1, 1, 1, 1, 0);
    step("R2", 0, 0, 1, 1, 9);
    step("R3", 1, 0, 1, 1, 10);
    step("R2", 0, 1, 0, 0, 0);

    // R9: pulses between edges have no effect
    step("R3", 1, 0, 0, 0, 6);
    @(posedge clk); #3;
    clr_n = 1'b0; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 4'd2;
    #4;
    clr_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = 4'd0;
    @(negedge clk);
    chk("R9", int'(q), 6);
    @(posedge clk); @(negedge clk);
    chk("R9", int'(q), 6);

    // R1 mid-operation
    step("R4", 1, 1, 1, 1, 0);
    rst = 1'b1;
    clr_n = 1'b1; load_n = 1'b0; din = 4'd11; en_par = 1'b1; en_trk = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", int'(q), 0);
    chk("R1", int'(c_q), 0);
    rst = 1'b0; exp_q = 0; exp_c = 0;
    step("R4", 1, 1, 1, 1, 0);

    // chain
    cstep("R8", 1, 0, 0, 4093);
    cstep("R8", 1, 1, 1, 0);
    cstep("R8", 1, 1, 1, 0);
    cstep("R8", 1, 1, 1, 0);
    cstep("R8", 1, 1, 1, 0);
    cstep("R8", 1, 0, 0, 254);
    for (int i = 0; i < 4; i++) cstep("R8", 1, 1, 1, 0);
    cstep("R8", 1, 1, 0, 0);
    cstep("R8", 1, 0, 1, 1503);
    cstep("R8", 0, 0, 1, 77);
    for (int i = 0; i < 20; i++) cstep("R8", 1, 1, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule